// File: doc/BRIEF.md
# Shared Instruction Block Buffer with Waiter Counts

This block sits between an in-order fetch stage and an instruction memory port. It keeps a few recently used instruction cache blocks. Each block is tagged by a thread address-space identifier and a block-aligned address. Fetch works in two steps. The initiate step declares the address an instruction will need. It either joins an existing buffered or in-flight block, or starts one block-sized memory read. The complete step collects the instruction word once the block's data is present.

In-flight reads are tracked in a pending table that is separate from the buffer. Every entry in the buffer or the pending table counts the instructions still waiting on it. Admission of new work is limited by the number of pending entries plus the number of buffer entries that still have waiters. Replacement picks the least recently used buffer entry that has no waiters. A squash cancels one waiter. A flush empties both structures.

Top module: `fetch_blk_buf`

## Requirements
- R1: An entry matches only when both its address-space ID and its block address (address bits above the in-block offset) equal the probe.
- R2: An accepted initiate that matches a pending entry adds a waiter to that entry and issues no memory read. This holds even when occupancy is at capacity.
- R3: If no pending entry matches, occupancy is below capacity and a buffer entry matches, the initiate is accepted, adds a waiter to that entry and issues no read. Occupancy is the number of pending entries plus the number of buffer entries with a nonzero count.
- R4: An initiate that matches no pending entry is refused (`init_accept_o` low, no read) when occupancy is at or above capacity, even if a buffer entry matches.
- R5: An accepted initiate that matches nothing issues a read in the same cycle. The read address is the block-aligned address, and `mem_rd_tag_o` names the pending slot allocated with one waiter. A response carrying that tag fills the slot.
- R6: The returned word is the word at index (address offset within the block) / (INSN_W/8). Word k occupies bits [k*INSN_W +: INSN_W] of the block data.
- R7: A complete request raises `insn_valid_o` with the word in the next cycle when the block is buffered, or is pending with its data returned. If the data has not returned, nothing is produced and the requester retries.
- R8: When a pending block is completed into a full buffer, the victim is the least recently used buffer entry with zero waiters. Completes that are served, and promotions, make their entry the most recently used.
- R9: A squash removes one waiter from the matching buffer entry, or else from the matching pending entry. A pending entry left with no waiters is discarded, so a later initiate for that block issues a new read.
- R10: A flush empties the buffer and the pending table, so the next initiate for any formerly held block issues a read.
- R11: While `port_blocked_i` is high, every initiate is refused.
- R12: Only one operation takes effect per cycle, in the order squash, complete, initiate. Initiates that lose are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty buffer and pending table |
| port_blocked_i | input | 1 | Memory port cannot take a request |
| init_valid_i | input | 1 | Initiate request |
| init_asid_i | input | ASID_W | Initiate address-space ID |
| init_addr_i | input | ADDR_W | Initiate byte address |
| init_accept_o | output | 1 | Initiate taken this cycle |
| mem_rd_valid_o | output | 1 | Block read issued this cycle |
| mem_rd_addr_o | output | ADDR_W | Block-aligned read address |
| mem_rd_tag_o | output | IDX_W | Pending slot of the read |
| mem_rsp_valid_i | input | 1 | Block data returned |
| mem_rsp_tag_i | input | IDX_W | Pending slot of the returned data |
| mem_rsp_data_i | input | BLK_W | Returned block |
| cmpl_valid_i | input | 1 | Complete request |
| cmpl_asid_i | input | ASID_W | Complete address-space ID |
| cmpl_addr_i | input | ADDR_W | Complete byte address |
| insn_valid_o | output | 1 | Instruction word delivered |
| insn_o | output | INSN_W | Instruction word |
| sq_valid_i | input | 1 | Squash one waiter |
| sq_asid_i | input | ASID_W | Squash address-space ID |
| sq_addr_i | input | ADDR_W | Squash byte address |

## Verification
Accept and read-issue are combinational responses to an initiate. They are sampled one nanosecond after the inputs change at the falling edge, before the next rising edge commits the state. The instruction word is registered, so it is checked just after the rising edge that ends the complete cycle. Squash, flush and returned data have no direct output. Their effect is checked through later initiates, by whether a read is issued and by the accept level.

// File: rtl/fbb_pkg.sv
`timescale 1ns/1ps
package fbb_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_INIT, OP_CMPL, OP_SQ} op_e;
endpackage

// File: rtl/fbb_cam.sv
`timescale 1ns/1ps
module fbb_cam #(
  parameter int N  = 4,
  parameter int KW = 35,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld_i,
  input  logic [N-1:0][KW-1:0] key_i,
  input  logic [KW-1:0]        probe_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_i[i] && key_i[i] == probe_i) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fbb_victim.sv
`timescale 1ns/1ps
module fbb_victim #(
  parameter int N  = 4,
  parameter int AW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][AW-1:0] age_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  logic [AW-1:0] best;
  // oldest eligible entry wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || age_i[i] > best)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = age_i[i];
      end
    end
  end
endmodule

// File: rtl/fbb_word_sel.sv
`timescale 1ns/1ps
module fbb_word_sel #(
  parameter int BLK_W = 256,
  parameter int W     = 32,
  localparam int NW   = BLK_W / W,
  localparam int SW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [SW-1:0]    sel_i,
  output logic [W-1:0]     word_o
);
  logic [W-1:0] words [NW];
  for (genvar g = 0; g < NW; g++) begin : g_word
    assign words[g] = blk_i[g*W +: W];
  end
  assign word_o = words[sel_i];
endmodule

// File: rtl/fetch_blk_buf.sv
`timescale 1ns/1ps
module fetch_blk_buf
  import fbb_pkg::*;
#(
  parameter int NUM_ENT   = 4,
  parameter int BLK_BYTES = 32,
  parameter int INSN_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int ASID_W    = 8,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int BLK_W    = BLK_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              port_blocked_i,
  input  logic              init_valid_i,
  input  logic [ASID_W-1:0] init_asid_i,
  input  logic [ADDR_W-1:0] init_addr_i,
  output logic              init_accept_o,
  output logic              mem_rd_valid_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic [IDX_W-1:0]  mem_rd_tag_o,
  input  logic              mem_rsp_valid_i,
  input  logic [IDX_W-1:0]  mem_rsp_tag_i,
  input  logic [BLK_W-1:0]  mem_rsp_data_i,
  input  logic              cmpl_valid_i,
  input  logic [ASID_W-1:0] cmpl_asid_i,
  input  logic [ADDR_W-1:0] cmpl_addr_i,
  output logic              insn_valid_o,
  output logic [INSN_W-1:0] insn_o,
  input  logic              sq_valid_i,
  input  logic [ASID_W-1:0] sq_asid_i,
  input  logic [ADDR_W-1:0] sq_addr_i
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IB    = $clog2(INSN_W / 8);
  localparam int SEL_W = OFF_W - IB;
  localparam int AGE_W = IDX_W + 1;
  localparam int KEY_W = ASID_W + TAG_W;
  localparam int OCC_W = IDX_W + 2;

  op_e               op;
  logic [ASID_W-1:0] key_asid;
  logic [ADDR_W-1:0] key_addr;
  logic [KEY_W-1:0]  probe;

  logic [NUM_ENT-1:0]             b_vld, p_vld, p_dv, b_zero;
  logic [NUM_ENT-1:0][KEY_W-1:0]  b_key, p_key;
  logic [NUM_ENT-1:0][CNT_W-1:0]  b_cnt, p_cnt;
  logic [NUM_ENT-1:0][AGE_W-1:0]  b_age;
  logic [NUM_ENT-1:0][BLK_W-1:0]  b_data, p_data;

  logic             b_hit, p_hit, vic_found, room, b_full;
  logic [IDX_W-1:0] b_idx, p_idx, vic_idx, b_free, p_free, pr_dst, t_idx;
  logic [OCC_W-1:0] occ;
  logic [AGE_W-1:0] t_rank;
  logic             in_ok, mrg_p, mrg_b, miss;
  logic             cm, cm_buf, pr_ready, pr_need_vic, cm_pro, t_en;
  logic             sq_b, sq_p;
  logic [BLK_W-1:0] blk_sel;
  logic [INSN_W-1:0] word;
  logic             unused_lo;

  // one operation per cycle: squash, complete, initiate
  always_comb begin
    if (sq_valid_i)        op = OP_SQ;
    else if (cmpl_valid_i) op = OP_CMPL;
    else if (init_valid_i) op = OP_INIT;
    else                   op = OP_NONE;
    case (op)
      OP_SQ:   begin key_asid = sq_asid_i;   key_addr = sq_addr_i;   end
      OP_CMPL: begin key_asid = cmpl_asid_i; key_addr = cmpl_addr_i; end
      default: begin key_asid = init_asid_i; key_addr = init_addr_i; end
    endcase
  end
  assign probe     = {key_asid, key_addr[ADDR_W-1:OFF_W]};
  assign unused_lo = ^key_addr[IB-1:0];

  fbb_cam #(.N(NUM_ENT), .KW(KEY_W)) u_bcam (
    .vld_i(b_vld), .key_i(b_key), .probe_i(probe), .hit_o(b_hit), .idx_o(b_idx));
  fbb_cam #(.N(NUM_ENT), .KW(KEY_W)) u_pcam (
    .vld_i(p_vld), .key_i(p_key), .probe_i(probe), .hit_o(p_hit), .idx_o(p_idx));

  always_comb begin
    occ    = '0;
    b_free = '0;
    p_free = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      b_zero[i] = (b_cnt[i] == '0);
      occ = occ + OCC_W'(p_vld[i]) + OCC_W'(b_vld[i] & ~b_zero[i]);
      if (!b_vld[i]) b_free = IDX_W'(i);
      if (!p_vld[i]) p_free = IDX_W'(i);
    end
  end
  assign room   = occ < OCC_W'(NUM_ENT);
  assign b_full = &b_vld;

  fbb_victim #(.N(NUM_ENT), .AW(AGE_W)) u_vic (
    .cand_i(b_vld & b_zero), .age_i(b_age), .found_o(vic_found), .idx_o(vic_idx));

  // initiate
  assign in_ok          = (op == OP_INIT) && !port_blocked_i;
  assign mrg_p          = in_ok && p_hit;
  assign mrg_b          = in_ok && !p_hit && room && b_hit;
  assign miss           = in_ok && !p_hit && room && !b_hit;
  assign init_accept_o  = mrg_p || mrg_b || miss;
  assign mem_rd_valid_o = miss;
  assign mem_rd_addr_o  = {key_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_rd_tag_o   = p_free;

  // complete
  assign cm          = (op == OP_CMPL);
  assign cm_buf      = cm && b_hit;
  assign pr_ready    = cm && !b_hit && p_hit && p_dv[p_idx];
  assign pr_need_vic = pr_ready && b_full;
  assign pr_dst      = b_full ? vic_idx : b_free;
  assign cm_pro      = pr_ready && (!b_full || vic_found);

  // squash
  assign sq_b = (op == OP_SQ) && b_hit && !b_zero[b_idx];
  assign sq_p = (op == OP_SQ) && !b_hit && p_hit && (p_cnt[p_idx] != '0);

  assign blk_sel = cm_buf ? b_data[b_idx] : p_data[p_idx];
  fbb_word_sel #(.BLK_W(BLK_W), .W(INSN_W)) u_wsel (
    .blk_i(blk_sel), .sel_i(key_addr[OFF_W-1:IB]), .word_o(word));

  // recency: touched entry becomes 0, younger valid entries age by one
  assign t_en   = cm_buf || cm_pro;
  assign t_idx  = cm_buf ? b_idx : pr_dst;
  assign t_rank = (cm_buf || b_vld[pr_dst]) ? b_age[t_idx] : AGE_W'(NUM_ENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_vld <= '0; b_key <= '0; b_cnt <= '0; b_age <= '0; b_data <= '0;
      insn_valid_o <= 1'b0; insn_o <= '0;
    end else if (flush_i) begin
      b_vld <= '0; insn_valid_o <= 1'b0;
    end else begin
      insn_valid_o <= t_en;
      if (t_en) insn_o <= word;
      if (t_en) begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (IDX_W'(i) == t_idx) b_age[i] <= '0;
          else if (b_vld[i] && b_age[i] < t_rank) b_age[i] <= b_age[i] + 1'b1;
        end
      end
      if (mrg_b) b_cnt[b_idx] <= b_cnt[b_idx] + 1'b1;
      if ((cm_buf && !b_zero[b_idx]) || sq_b) b_cnt[b_idx] <= b_cnt[b_idx] - 1'b1;
      if (cm_pro) begin
        b_vld[pr_dst]  <= 1'b1;
        b_key[pr_dst]  <= p_key[p_idx];
        b_data[pr_dst] <= p_data[p_idx];
        b_cnt[pr_dst]  <= p_cnt[p_idx] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld <= '0; p_dv <= '0; p_key <= '0; p_cnt <= '0; p_data <= '0;
    end else if (flush_i) begin
      p_vld <= '0;
    end else begin
      if (miss) begin
        p_vld[p_free] <= 1'b1;
        p_dv[p_free]  <= 1'b0;
        p_key[p_free] <= probe;
        p_cnt[p_free] <= CNT_W'(1);
      end
      if (mrg_p) p_cnt[p_idx] <= p_cnt[p_idx] + 1'b1;
      if (sq_p) begin
        p_cnt[p_idx] <= p_cnt[p_idx] - 1'b1;
        if (p_cnt[p_idx] == CNT_W'(1)) p_vld[p_idx] <= 1'b0;
      end
      if (cm_pro) p_vld[p_idx] <= 1'b0;
      if (mem_rsp_valid_i && p_vld[mem_rsp_tag_i] && !p_dv[mem_rsp_tag_i]) begin
        p_dv[mem_rsp_tag_i]   <= 1'b1;
        p_data[mem_rsp_tag_i] <= mem_rsp_data_i;
      end
    end
  end
endmodule

// File: rtl/fbb_chk.sv
`timescale 1ns/1ps
module fbb_chk #(
  parameter int NUM_ENT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               port_blocked_i,
  input logic               init_valid_i,
  input logic               acc_i,
  input logic               rd_i,
  input logic               cmpl_valid_i,
  input logic               sq_valid_i,
  input logic               insn_valid_i,
  input logic [NUM_ENT-1:0] b_vld_i,
  input logic [NUM_ENT-1:0] p_vld_i,
  input logic               need_vic_i,
  input logic               vic_found_i
);
  // R11
  blocked_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_blocked_i |-> !acc_i);
  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (b_vld_i == '0 && p_vld_i == '0));
  // R5
  rd_needs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (acc_i && init_valid_i));
  // R7
  insn_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i |-> $past(cmpl_valid_i && !sq_valid_i && !flush_i));
  // R8
  victim_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_vic_i |-> vic_found_i);
  // R12
  prio_sq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_valid_i || cmpl_valid_i) |-> (!acc_i && !rd_i));
endmodule

bind fetch_blk_buf fbb_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .port_blocked_i(port_blocked_i),
  .init_valid_i(init_valid_i), .acc_i(init_accept_o), .rd_i(mem_rd_valid_o),
  .cmpl_valid_i(cmpl_valid_i), .sq_valid_i(sq_valid_i), .insn_valid_i(insn_valid_o),
  .b_vld_i(b_vld), .p_vld_i(p_vld), .need_vic_i(pr_need_vic), .vic_found_i(vic_found));

// File: tb/fetch_blk_buf_tb.sv
`timescale 1ns/1ps
module fetch_blk_buf_tb;
  localparam int BLK_W = 256;
  localparam logic [2:0] KI = 3'd0, KC = 3'd1, KS = 3'd2, KP = 3'd3, KF = 3'd4;

  typedef struct packed {
    logic [2:0]  k;
    logic [7:0]  asid;
    logic [31:0] addr;   // read ordinal for KP
    logic        acc;
    logic        rd;
    logic        iv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{KI, 8'd1, 32'h1004, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 miss
    '{KI, 8'd1, 32'h1008, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 merge pending
    '{KI, 8'd2, 32'h1008, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 other asid misses
    '{KC, 8'd1, 32'h1004, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 data not back
    '{KP, 8'd0, 32'd0,    1'b0, 1'b0, 1'b0, 4'd5},
    '{KC, 8'd1, 32'h1004, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
    '{KC, 8'd1, 32'h1008, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 buffer hit
    '{KI, 8'd1, 32'h101C, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 buffer merge
    '{KC, 8'd1, 32'h101C, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 last word
    '{KI, 8'd1, 32'h2000, 1'b1, 1'b1, 1'b0, 4'd5},
    '{KI, 8'd1, 32'h3000, 1'b1, 1'b1, 1'b0, 4'd5},
    '{KI, 8'd1, 32'h4000, 1'b1, 1'b1, 1'b0, 4'd5},
    '{KI, 8'd1, 32'h1000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 buffer hit, full
    '{KI, 8'd1, 32'h5000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 miss, full
    '{KI, 8'd2, 32'h1010, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 while full
    '{KS, 8'd2, 32'h1010, 1'b0, 1'b0, 1'b0, 4'd9},
    '{KS, 8'd2, 32'h1000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 discard
    '{KI, 8'd2, 32'h1000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 new read
    '{KP, 8'd0, 32'd2,    1'b0, 1'b0, 1'b0, 4'd5},
    '{KC, 8'd1, 32'h2000, 1'b0, 1'b0, 1'b1, 4'd7},
    '{KI, 8'd1, 32'h1000, 1'b1, 1'b0, 1'b0, 4'd3},
    '{KC, 8'd1, 32'h1000, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 touch
    '{KP, 8'd0, 32'd3,    1'b0, 1'b0, 1'b0, 4'd5},
    '{KC, 8'd1, 32'h3000, 1'b0, 1'b0, 1'b1, 4'd7},
    '{KP, 8'd0, 32'd4,    1'b0, 1'b0, 1'b0, 4'd5},
    '{KC, 8'd1, 32'h4000, 1'b0, 1'b0, 1'b1, 4'd7},
    '{KP, 8'd0, 32'd5,    1'b0, 1'b0, 1'b0, 4'd5},
    '{KC, 8'd2, 32'h1008, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 evicts 0x2000
    '{KI, 8'd1, 32'h1000, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 kept
    '{KI, 8'd1, 32'h2000, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 evicted
    '{KF, 8'd0, 32'd0,    1'b0, 1'b0, 1'b0, 4'd10},
    '{KI, 8'd1, 32'h3000, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
    '{KP, 8'd0, 32'd7,    1'b0, 1'b0, 1'b0, 4'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush, blocked, init_v, rsp_v, cmpl_v, sq_v;
  logic [7:0] init_asid, cmpl_asid, sq_asid;
  logic [31:0] init_addr, cmpl_addr, sq_addr, rd_addr, insn;
  logic [1:0] rd_tag, rsp_tag;
  logic [BLK_W-1:0] rsp_data;
  logic acc, rd_v, insn_v;

  int total = 0, bad = 0, nrd = 0;
  bit done = 0;
  logic [31:0] rd_a [16];
  logic [1:0]  rd_t [16];

  always #2 clk = ~clk;

  fetch_blk_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .port_blocked_i(blocked),
    .init_valid_i(init_v), .init_asid_i(init_asid), .init_addr_i(init_addr),
    .init_accept_o(acc), .mem_rd_valid_o(rd_v), .mem_rd_addr_o(rd_addr),
    .mem_rd_tag_o(rd_tag), .mem_rsp_valid_i(rsp_v), .mem_rsp_tag_i(rsp_tag),
    .mem_rsp_data_i(rsp_data), .cmpl_valid_i(cmpl_v), .cmpl_asid_i(cmpl_asid),
    .cmpl_addr_i(cmpl_addr), .insn_valid_o(insn_v), .insn_o(insn),
    .sq_valid_i(sq_v), .sq_asid_i(sq_asid), .sq_addr_i(sq_addr));

  function automatic logic [31:0] mw(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; blocked = 0; init_v = 0; rsp_v = 0; cmpl_v = 0; sq_v = 0;
    init_asid = 0; cmpl_asid = 0; sq_asid = 0; init_addr = 0; cmpl_addr = 0;
    sq_addr = 0; rsp_tag = 0; rsp_data = '0;
  endtask

  // combinational results before the edge, registered word after it
  task automatic sample(string r, logic e_acc, logic e_rd, logic e_iv, logic [31:0] wa);
    #1;
    if (init_v) begin
      chk({r, " accept"}, 32'(acc), 32'(e_acc));
      chk({r, " read"}, 32'(rd_v), 32'(e_rd));
      if (rd_v && acc) begin
        chk("R5 read addr", rd_addr, {init_addr[31:5], 5'd0});
        rd_a[nrd] = rd_addr; rd_t[nrd] = rd_tag; nrd++;
      end
    end
    @(posedge clk); #1;
    if (cmpl_v) begin
      chk({r, " insn_valid"}, 32'(insn_v), 32'(e_iv));
      if (e_iv) chk({r, " insn"}, insn, mw(wa));
    end
  endtask

  task automatic apply(vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    @(negedge clk); idle();
    case (v.k)
      KI: begin init_v = 1; init_asid = v.asid; init_addr = v.addr; end
      KC: begin cmpl_v = 1; cmpl_asid = v.asid; cmpl_addr = v.addr; end
      KS: begin sq_v = 1; sq_asid = v.asid; sq_addr = v.addr; end
      KP: begin
        rsp_v = 1; rsp_tag = rd_t[v.addr];
        for (int w = 0; w < 8; w++) rsp_data[w*32 +: 32] = mw(rd_a[v.addr] + 32'(4 * w));
      end
      default: flush = 1;
    endcase
    sample(r, v.acc, v.rd, v.iv, v.addr);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset insn_valid", 32'(insn_v), 0);
    chk("R5 reset read", 32'(rd_v), 0);
    chk("R3 reset accept", 32'(acc), 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < NV; i++) apply(VEC[i]);
    // R12: complete beats initiate
    @(negedge clk); idle();
    cmpl_v = 1; cmpl_asid = 1; cmpl_addr = 32'h3004;
    init_v = 1; init_asid = 1; init_addr = 32'h4000;
    sample("R12 cmpl+init", 1'b0, 1'b0, 1'b1, 32'h3004);
    // R12: squash beats initiate
    @(negedge clk); idle();
    sq_v = 1; sq_asid = 1; sq_addr = 32'h3000;
    init_v = 1; init_asid = 1; init_addr = 32'h4000;
    sample("R12 sq+init", 1'b0, 1'b0, 1'b0, 0);
    // R11: blocked port refuses
    @(negedge clk); idle();
    blocked = 1; init_v = 1; init_asid = 1; init_addr = 32'h4000;
    sample("R11 blocked", 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk); idle();
    init_v = 1; init_asid = 1; init_addr = 32'h4000;
    sample("R11 unblocked", 1'b1, 1'b1, 1'b0, 0);
    @(negedge clk); idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule